// File: doc/BRIEF.md
# Control Register Scoreboard Interlock

This block guards the ordering of writes to internal control registers against later instructions that read or write them. The registers are split into eight scoreboard groups. When an explicit write is accepted at the map stage, every group named in its mask is marked busy and remembers the tag and fetch-block id of that writer. A later explicit read, a later explicit write, or a memory operation (which implicitly reads the translation group) is held at the map stage while it touches a busy group owned by a writer from a different fetch block. Instructions that share a fetch block with the owning writer are not compared against it.

A group frees itself when its owning writer retires or is aborted. Only the newest owner's tag can release a group, so a retirement of an older writer does not free a group that a younger writer has since claimed. Reads of write-one-to-clear status bits and performance counters use a separate kind that is never interlocked. A return instruction with its stall bit set closes a fetch gate once it is mapped. While the gate is closed, every younger descriptor is stalled, until that return retires or is aborted.

Top module: `ctlreg_scoreboard`

## Requirements
- R1: While and after reset, `groupBusy` is all zeros and `mapStall` and `fetchHold` are low.
- R2: A descriptor with `mapValid` high, `mapKind`=1 (explicit write) and `mapStall` low sets every `groupBusy` bit named in `mapGroups` (bit i = group i) at the next clock edge.
- R3: An explicit write (kind 1) or explicit read (kind 2) drives `mapStall` high in the same cycle when any group in its `mapGroups` is busy with an owner from a different `mapFetchBlk`. A stalled descriptor changes no stored state.
- R4: No stall is raised against a busy group whose owning writer carried the same `mapFetchBlk` value as the current descriptor.
- R5: A memory operation (kind 3) checks only the translation group (group 0, parameter `XLAT_GROUP`) and ignores `mapGroups`.
- R6: Kinds 0 (other) and 5 (uninterlocked read of clear-on-write or counter registers) never stall while the fetch gate is open, even when their mask names busy groups.
- R7: A busy group clears at the next edge when `retireValid` or `abortValid` carries the tag of its newest owner. A tag that does not match leaves the group busy.
- R8: When a write is accepted in the same cycle as the retirement of the group's previous owner, the group stays busy and is owned by the new writer.
- R9: An accepted stalling return (kind 4) raises `fetchHold` at the next edge. While `fetchHold` is high, every valid descriptor stalls. `fetchHold` drops at the edge after that return's tag retires or aborts, and other tags leave it high.
- R10: With `mapValid` low, `mapStall` is low and no group is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mapValid | input | 1 | A descriptor is presented at the map stage |
| mapKind | input | 3 | 0 other, 1 explicit write, 2 explicit read, 3 memory op, 4 stalling return, 5 uninterlocked read |
| mapGroups | input | NUM_GROUPS | Scoreboard groups touched, one bit per group |
| mapFetchBlk | input | FB_W | Aligned fetch-block id of the descriptor |
| mapTag | input | TAG_W | Instruction tag |
| retireValid | input | 1 | An instruction retires this cycle |
| retireTag | input | TAG_W | Tag of the retiring instruction |
| abortValid | input | 1 | An instruction is aborted this cycle |
| abortTag | input | TAG_W | Tag of the aborted instruction |
| mapStall | output | 1 | Hold the current descriptor at the map stage |
| groupBusy | output | NUM_GROUPS | Busy flag for each scoreboard group |
| fetchHold | output | 1 | Fetch gate closed behind a stalling return |

## Verification
On every cycle the assertions check four things: no busy bit appears without an accepted write, no busy bit drops without a retire or abort, an idle or gated map stage behaves as required, and the uninterlocked kinds never stall. Some behaviour depends on which writer owns a group, so only the directed scenarios can show it. These cover the same-fetch-block exemption, a memory operation ignoring its mask, a non-matching retire leaving a group busy, and a younger writer keeping a group that an older writer's retirement would otherwise free.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

  typedef enum logic [2:0] {
    K_OTHER    = 3'd0,
    K_WRITE    = 3'd1,
    K_READ     = 3'd2,
    K_MEMOP    = 3'd3,
    K_RETSTALL = 3'd4,
    K_RAWREAD  = 3'd5
  } mapKind_e;

  // Strobes from control to the group datapath
  typedef struct packed {
    logic checkGroups;  // compare the descriptor's mask against busy groups
    logic checkXlat;    // compare only the translation group
    logic writeEn;      // accepted explicit write: claim the masked groups
  } sbStrobe_t;

endpackage

// File: rtl/sbi_group_slot.sv
module sbi_group_slot #(
  parameter int TAG_W = 6,
  parameter int FB_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setEn,
  input  logic [TAG_W-1:0] setTag,
  input  logic [FB_W-1:0]  setFb,
  input  logic             retireValid,
  input  logic [TAG_W-1:0] retireTag,
  input  logic             abortValid,
  input  logic [TAG_W-1:0] abortTag,
  input  logic             needCheck,
  input  logic [FB_W-1:0]  curFb,
  output logic             busy,
  output logic             conflict
);

  logic [TAG_W-1:0] ownerTag;
  logic [FB_W-1:0]  ownerFb;
  logic             retireHit;
  logic             abortHit;
  logic             clearHit;

  always_comb begin
    retireHit = retireValid && (retireTag == ownerTag);
    abortHit  = abortValid && (abortTag == ownerTag);
    clearHit  = busy && (retireHit || abortHit);
    // same fetch block is never compared
    conflict  = busy && needCheck && (ownerFb != curFb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      ownerTag <= '0;
      ownerFb  <= '0;
    end else if (setEn) begin
      // a newer writer wins over a same-cycle release of the old owner
      busy     <= 1'b1;
      ownerTag <= setTag;
      ownerFb  <= setFb;
    end else if (clearHit) begin
      busy     <= 1'b0;
    end
  end

endmodule

// File: rtl/sbi_groups.sv
module sbi_groups
  import sbi_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int TAG_W      = 6,
  parameter int FB_W       = 4,
  parameter int XLAT_GROUP = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sbStrobe_t             strobes,
  input  logic [NUM_GROUPS-1:0] mapGroups,
  input  logic [FB_W-1:0]       mapFetchBlk,
  input  logic [TAG_W-1:0]      mapTag,
  input  logic                  retireValid,
  input  logic [TAG_W-1:0]      retireTag,
  input  logic                  abortValid,
  input  logic [TAG_W-1:0]      abortTag,
  output logic [NUM_GROUPS-1:0] busyVec,
  output logic                  anyConflict
);

  localparam logic [NUM_GROUPS-1:0] XLAT_MASK = NUM_GROUPS'(1) << XLAT_GROUP;

  logic [NUM_GROUPS-1:0] needMask;
  logic [NUM_GROUPS-1:0] setMask;
  logic [NUM_GROUPS-1:0] conflictVec;

  always_comb begin
    needMask = '0;
    if (strobes.checkGroups) needMask = needMask | mapGroups;
    if (strobes.checkXlat)   needMask = needMask | XLAT_MASK;
    setMask     = strobes.writeEn ? mapGroups : '0;
    anyConflict = |conflictVec;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gSlot
    sbi_group_slot #(
      .TAG_W(TAG_W),
      .FB_W (FB_W)
    ) slot_i (
      .clk        (clk),
      .rstN       (rstN),
      .setEn      (setMask[g]),
      .setTag     (mapTag),
      .setFb      (mapFetchBlk),
      .retireValid(retireValid),
      .retireTag  (retireTag),
      .abortValid (abortValid),
      .abortTag   (abortTag),
      .needCheck  (needMask[g]),
      .curFb      (mapFetchBlk),
      .busy       (busyVec[g]),
      .conflict   (conflictVec[g])
    );
  end

endmodule

// File: rtl/sbi_ctl.sv
module sbi_ctl
  import sbi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mapValid,
  input  logic [2:0]       mapKind,
  input  logic [TAG_W-1:0] mapTag,
  input  logic             anyConflict,
  input  logic             retireValid,
  input  logic [TAG_W-1:0] retireTag,
  input  logic             abortValid,
  input  logic [TAG_W-1:0] abortTag,
  output sbStrobe_t        strobes,
  output logic             mapStall,
  output logic             fetchHold
);

  logic             isWrite;
  logic             isRead;
  logic             isMemOp;
  logic             isRetStall;
  logic             gateOn;
  logic [TAG_W-1:0] gateTag;
  logic             gateSet;
  logic             gateRelease;

  always_comb begin
    isWrite    = (mapKind == K_WRITE);
    isRead     = (mapKind == K_READ);
    isMemOp    = (mapKind == K_MEMOP);
    isRetStall = (mapKind == K_RETSTALL);

    strobes.checkGroups = mapValid && (isWrite || isRead);
    strobes.checkXlat   = mapValid && isMemOp;

    mapStall = mapValid && (gateOn || anyConflict);

    strobes.writeEn = mapValid && isWrite && !mapStall;
    gateSet         = mapValid && isRetStall && !mapStall;
    gateRelease     = gateOn && ((retireValid && retireTag == gateTag) ||
                                 (abortValid && abortTag == gateTag));
    fetchHold       = gateOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOn  <= 1'b0;
      gateTag <= '0;
    end else if (gateSet) begin
      gateOn  <= 1'b1;
      gateTag <= mapTag;
    end else if (gateRelease) begin
      gateOn  <= 1'b0;
    end
  end

endmodule

// File: rtl/ctlreg_scoreboard.sv
module ctlreg_scoreboard
  import sbi_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int TAG_W      = 6,
  parameter int FB_W       = 4,
  parameter int XLAT_GROUP = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mapValid,
  input  logic [2:0]            mapKind,
  input  logic [NUM_GROUPS-1:0] mapGroups,
  input  logic [FB_W-1:0]       mapFetchBlk,
  input  logic [TAG_W-1:0]      mapTag,
  input  logic                  retireValid,
  input  logic [TAG_W-1:0]      retireTag,
  input  logic                  abortValid,
  input  logic [TAG_W-1:0]      abortTag,
  output logic                  mapStall,
  output logic [NUM_GROUPS-1:0] groupBusy,
  output logic                  fetchHold
);

  sbStrobe_t strobes;
  logic      anyConflict;

  sbi_ctl #(.TAG_W(TAG_W)) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .mapValid   (mapValid),
    .mapKind    (mapKind),
    .mapTag     (mapTag),
    .anyConflict(anyConflict),
    .retireValid(retireValid),
    .retireTag  (retireTag),
    .abortValid (abortValid),
    .abortTag   (abortTag),
    .strobes    (strobes),
    .mapStall   (mapStall),
    .fetchHold  (fetchHold)
  );

  sbi_groups #(
    .NUM_GROUPS(NUM_GROUPS),
    .TAG_W     (TAG_W),
    .FB_W      (FB_W),
    .XLAT_GROUP(XLAT_GROUP)
  ) groups_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .mapGroups  (mapGroups),
    .mapFetchBlk(mapFetchBlk),
    .mapTag     (mapTag),
    .retireValid(retireValid),
    .retireTag  (retireTag),
    .abortValid (abortValid),
    .abortTag   (abortTag),
    .busyVec    (groupBusy),
    .anyConflict(anyConflict)
  );

endmodule

// File: rtl/sbi_checker.sv
module sbi_checker
  import sbi_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int TAG_W      = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  mapValid,
  input logic [2:0]            mapKind,
  input logic [NUM_GROUPS-1:0] mapGroups,
  input logic                  retireValid,
  input logic                  abortValid,
  input logic                  mapStall,
  input logic [NUM_GROUPS-1:0] groupBusy,
  input logic                  fetchHold
);

  // R1: busy bits never appear while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) a_r1_reset_idle: assert (groupBusy == '0 && !fetchHold);
  end

  a_r2_write_claims: assert property (@(posedge clk) disable iff (!rstN)
    (mapValid && mapKind == K_WRITE && !mapStall) |=>
      ((groupBusy & $past(mapGroups)) == $past(mapGroups)));

  a_r3_busy_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    ((groupBusy & ~$past(groupBusy)) != '0) |->
      $past(mapValid && mapKind == K_WRITE && !mapStall));

  a_r6_free_kinds_pass: assert property (@(posedge clk) disable iff (!rstN)
    (mapValid && !fetchHold && (mapKind == K_OTHER || mapKind == K_RAWREAD)) |->
      !mapStall);

  a_r7_release_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    (($past(groupBusy) & ~groupBusy) != '0) |-> $past(retireValid || abortValid));

  a_r9_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (mapValid && fetchHold) |-> mapStall);

  a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !mapValid |-> !mapStall);

endmodule

bind ctlreg_scoreboard sbi_checker #(
  .NUM_GROUPS(NUM_GROUPS),
  .TAG_W     (TAG_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .mapValid   (mapValid),
  .mapKind    (mapKind),
  .mapGroups  (mapGroups),
  .retireValid(retireValid),
  .abortValid (abortValid),
  .mapStall   (mapStall),
  .groupBusy  (groupBusy),
  .fetchHold  (fetchHold)
);

// File: tb/ctlreg_scoreboard_tb_top.sv
module ctlreg_scoreboard_tb_top;

  localparam int NG = 8;
  localparam int TW = 6;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          mapValid;
  logic [2:0]    mapKind;
  logic [NG-1:0] mapGroups;
  logic [FW-1:0] mapFetchBlk;
  logic [TW-1:0] mapTag;
  logic          retireValid;
  logic [TW-1:0] retireTag;
  logic          abortValid;
  logic [TW-1:0] abortTag;
  logic          mapStall;
  logic [NG-1:0] groupBusy;
  logic          fetchHold;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctlreg_scoreboard #(.NUM_GROUPS(NG), .TAG_W(TW), .FB_W(FW), .XLAT_GROUP(0)) dut_i (
    .clk(clk), .rstN(rstN), .mapValid(mapValid), .mapKind(mapKind),
    .mapGroups(mapGroups), .mapFetchBlk(mapFetchBlk), .mapTag(mapTag),
    .retireValid(retireValid), .retireTag(retireTag),
    .abortValid(abortValid), .abortTag(abortTag),
    .mapStall(mapStall), .groupBusy(groupBusy), .fetchHold(fetchHold)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present inputs after a falling edge; results are sampled 1 ns later
  task automatic apply(input logic v, input logic [2:0] k, input logic [NG-1:0] g,
                       input logic [FW-1:0] fb, input logic [TW-1:0] tag,
                       input logic rv, input logic [TW-1:0] rt,
                       input logic av, input logic [TW-1:0] at);
    @(negedge clk);
    mapValid = v; mapKind = k; mapGroups = g; mapFetchBlk = fb; mapTag = tag;
    retireValid = rv; retireTag = rt; abortValid = av; abortTag = at;
    #1;
  endtask

  task automatic idle();
    apply(1'b0, 3'd0, '0, '0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic mapOp(input logic [2:0] k, input logic [NG-1:0] g,
                       input logic [FW-1:0] fb, input logic [TW-1:0] tag);
    apply(1'b1, k, g, fb, tag, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic retireOp(input logic [TW-1:0] t);
    apply(1'b0, 3'd0, '0, '0, '0, 1'b1, t, 1'b0, '0);
  endtask

  task automatic abortOp(input logic [TW-1:0] t);
    apply(1'b0, 3'd0, '0, '0, '0, 1'b0, '0, 1'b1, t);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    idle();
    chk("R1 busy in reset", groupBusy, 0);
    chk("R1 hold in reset", fetchHold, 0);
    @(negedge clk); rstN = 1'b1;
    idle();
    chk("R1 busy after reset", groupBusy, 0);
    chk("R1 stall after reset", mapStall, 0);
  endtask

  task automatic testWriteRead();
    mapOp(3'd1, 8'h06, 4'd1, 6'd5);
    chk("R2 first write not stalled", mapStall, 0);
    idle();
    chk("R2 groups claimed", groupBusy, 8'h06);
    mapOp(3'd2, 8'h02, 4'd2, 6'd6);
    chk("R3 read of busy group stalls", mapStall, 1);
    mapOp(3'd2, 8'h02, 4'd1, 6'd6);
    chk("R4 same fetch block read passes", mapStall, 0);
    mapOp(3'd1, 8'h02, 4'd3, 6'd9);
    chk("R3 second writer stalls", mapStall, 1);
    apply(1'b0, 3'd1, 8'h80, 4'd3, 6'd9, 1'b0, '0, 1'b0, '0);
    chk("R10 invalid slot no stall", mapStall, 0);
    idle();
    chk("R10 invalid write claims nothing", groupBusy, 8'h06);
  endtask

  task automatic testFreeKinds();
    mapOp(3'd0, 8'h06, 4'd2, 6'd7);
    chk("R6 other kind passes", mapStall, 0);
    mapOp(3'd5, 8'h06, 4'd2, 6'd7);
    chk("R6 uninterlocked read passes", mapStall, 0);
  endtask

  task automatic testRelease();
    retireOp(6'd9);
    idle();
    chk("R7 foreign retire keeps busy", groupBusy, 8'h06);
    chk("R3 stalled writer left no owner", groupBusy, 8'h06);
    retireOp(6'd5);
    idle();
    chk("R7 owner retire clears", groupBusy, 8'h00);
  endtask

  task automatic testMemOp();
    mapOp(3'd1, 8'h01, 4'd4, 6'd10);
    idle();
    mapOp(3'd3, 8'h00, 4'd5, 6'd12);
    chk("R5 memop hits translation group", mapStall, 1);
    mapOp(3'd1, 8'h80, 4'd6, 6'd11);
    chk("R2 write to free group passes", mapStall, 0);
    abortOp(6'd10);
    idle();
    chk("R7 abort clears owner group", groupBusy, 8'h80);
    mapOp(3'd3, 8'h80, 4'd7, 6'd13);
    chk("R5 memop ignores its mask", mapStall, 0);
    retireOp(6'd11);
    idle();
    chk("R7 cleanup", groupBusy, 8'h00);
  endtask

  task automatic testOvertake();
    mapOp(3'd1, 8'h10, 4'd1, 6'd20);
    idle();
    apply(1'b1, 3'd1, 8'h10, 4'd1, 6'd21, 1'b1, 6'd20, 1'b0, '0);
    chk("R8 same-block rewrite passes", mapStall, 0);
    idle();
    chk("R8 new owner keeps group", groupBusy, 8'h10);
    retireOp(6'd20);
    idle();
    chk("R8 old tag cannot free group", groupBusy, 8'h10);
    retireOp(6'd21);
    idle();
    chk("R8 new owner frees group", groupBusy, 8'h00);
  endtask

  task automatic testGate();
    mapOp(3'd4, 8'h00, 4'd3, 6'd30);
    chk("R9 return itself passes", mapStall, 0);
    idle();
    chk("R9 gate closes", fetchHold, 1);
    mapOp(3'd0, 8'h00, 4'd4, 6'd31);
    chk("R9 younger op held", mapStall, 1);
    mapOp(3'd5, 8'h00, 4'd4, 6'd31);
    chk("R9 uninterlocked read held", mapStall, 1);
    retireOp(6'd31);
    idle();
    chk("R9 other tag keeps gate", fetchHold, 1);
    abortOp(6'd30);
    idle();
    chk("R9 abort opens gate", fetchHold, 0);
    mapOp(3'd0, 8'h00, 4'd5, 6'd32);
    chk("R9 flow resumes", mapStall, 0);
    idle();
  endtask

  initial begin
    rstN = 1'b0;
    mapValid = 1'b0; mapKind = '0; mapGroups = '0; mapFetchBlk = '0; mapTag = '0;
    retireValid = 1'b0; retireTag = '0; abortValid = 1'b0; abortTag = '0;
    testReset();
    testWriteRead();
    testFreeKinds();
    testRelease();
    testMemOp();
    testOvertake();
    testGate();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule